// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block is the command front end of an 8-bit parallel NOR flash. It watches a stream of synchronous write strobes, each carrying a full byte address and a data byte. It recognises the two-write unlock key and the command bytes that follow it. Program, sector-erase, block-erase and chip-erase commands end in a one-clock start pulse. The pulse carries an operation code, the target address and the data byte for the internal operation timer. Identification-entry, query-entry and exit commands switch the read mode that the array read path uses to select its data source.

While the operation timer reports busy, every write is dropped. This includes exit, so a running program or erase cannot be disturbed. Any write that does not continue a valid sequence sends the decoder back to idle. Only the low 15 address bits take part in command matching.

States: IDLE (no key seen), KEY1 (first key accepted), KEY2 (second key accepted, waiting for the command byte), PDATA (waiting for the program address and data), ERA3 (erase prefix accepted), ERA4 (fourth key accepted), ERA5 (fifth key accepted, waiting for the erase type). Transitions: IDLE→KEY1 on 0xAA at 0x5555. KEY1→KEY2 on 0x55 at 0x2AAA. KEY2→PDATA on 0xA0, KEY2→ERA3 on 0x80, and KEY2→IDLE on 0x90, 0x98 or 0xF0, all at 0x5555. PDATA→IDLE on any write, with a start. ERA3→ERA4 on 0xAA at 0x5555. ERA4→ERA5 on 0x55 at 0x2AAA. ERA5→IDLE on any write, with a start for a valid erase type. Any other write sends the decoder to IDLE.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After synchronous reset, start is 0, op_code is 0 (none), op_addr and op_data are 0, read_mode is 0 (array), and the decoder is idle.
- R2: The writes 0xAA@0x5555, 0x55@0x2AAA and 0xA0@0x5555, followed by a fourth write, raise start in the cycle after that fourth write with op_code 1 (program), op_addr equal to its full address and op_data equal to its byte.
- R3: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA and 0x10@0x5555 give a start with op_code 4 (chip erase), op_addr 0 and op_data 0x10.
- R4: The same five-write erase prefix followed by 0x30 at any address gives op_code 2 (sector erase) and op_addr equal to that address with bits 11..0 cleared.
- R5: The erase prefix followed by 0x50 at any address gives op_code 3 (block erase) and op_addr equal to that address with bits 15..0 cleared.
- R6: The unlock key followed by 0x90@0x5555 sets read_mode to 1 (identification). The key followed by 0x98@0x5555 sets read_mode to 2 (query). Either one is accepted from any read mode.
- R7: The unlock key followed by 0xF0@0x5555 sets read_mode to 0.
- R8: A single write of 0xF0 to any address, in any state except PDATA, sets read_mode to 0 and returns the decoder to idle.
- R9: A write with a wrong address or byte for the current step returns the decoder to idle without a start and leaves read_mode unchanged. The rest of an interrupted sequence then produces no start.
- R10: A write made while busy is 1 is ignored. It causes no start, does not change read_mode and does not advance or reset a sequence in progress.
- R11: Only address bits 14..0 are compared in command steps; bits above 14 are don't-care.
- R12: start is high for exactly one cycle per accepted operation, and op_code, op_addr and op_data hold their values until the next start.
- R13: In PDATA any byte, including 0xF0, is taken as program data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| busy | input | 1 | Internal program or erase in progress |
| start | output | 1 | One-cycle operation start pulse |
| op_code | output | 3 | 0 none, 1 program, 2 sector, 3 block, 4 chip |
| op_addr | output | ADDR_W | Latched target address |
| op_data | output | 8 | Latched data byte |
| read_mode | output | 2 | 0 array, 1 identification, 2 query |

## Verification
The bench builds the decoder with its default parameters: a 21-bit address, 4 KB sectors and 64 KB blocks. With the 21-bit address, the don't-care upper bits 15..20 can be driven to random values during command steps. With 64 KB blocks, the block alignment clears bit 15, which lies above the compare window, while sector alignment clears only bits inside it. Random command streams with corrupted steps and busy cycles are compared every cycle with a bench model of the requirements.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
    localparam int CMD_AW = 15;
    localparam logic [CMD_AW-1:0] UNLOCK_ADDR_A = 15'h5555;
    localparam logic [CMD_AW-1:0] UNLOCK_ADDR_B = 15'h2AAA;
    localparam logic [7:0] KEY_A      = 8'hAA;
    localparam logic [7:0] KEY_B      = 8'h55;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_ERASE  = 8'h80;
    localparam logic [7:0] CMD_ID     = 8'h90;
    localparam logic [7:0] CMD_QUERY  = 8'h98;
    localparam logic [7:0] CMD_EXIT   = 8'hF0;
    localparam logic [7:0] ERASE_CHIP = 8'h10;
    localparam logic [7:0] ERASE_SECT = 8'h30;
    localparam logic [7:0] ERASE_BLK  = 8'h50;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_SECTOR = 3'd2,
        OP_BLOCK  = 3'd3,
        OP_CHIP   = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        RM_ARRAY = 2'd0,
        RM_ID    = 2'd1,
        RM_QUERY = 2'd2
    } rmode_e;

    typedef enum logic [2:0] {
        S_IDLE, S_KEY1, S_KEY2, S_PDATA, S_ERA3, S_ERA4, S_ERA5
    } seq_e;

    typedef struct packed {
        logic key_a;
        logic key_b;
        logic at_a;
        logic exit_byte;
    } match_t;
endpackage

// File: rtl/nor_cmd_match.sv
module nor_cmd_match
    import nor_cmd_pkg::*;
(
    input  logic [CMD_AW-1:0] addr_lo,
    input  logic [7:0]        data,
    output match_t            hit
);
    logic at_a, at_b;

    always_comb begin
        at_a          = (addr_lo == UNLOCK_ADDR_A);
        at_b          = (addr_lo == UNLOCK_ADDR_B);
        hit.at_a      = at_a;
        hit.key_a     = at_a && (data == KEY_A);
        hit.key_b     = at_b && (data == KEY_B);
        hit.exit_byte = (data == CMD_EXIT);
    end
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int SECT_BITS = 12,
    parameter int BLK_BITS  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  match_t            hit,
    output logic              start,
    output op_e               op_code,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output rmode_e            read_mode
);
    localparam logic [ADDR_W-1:0] SECT_MASK = {ADDR_W{1'b1}} << SECT_BITS;
    localparam logic [ADDR_W-1:0] BLK_MASK  = {ADDR_W{1'b1}} << BLK_BITS;

    seq_e              st_q, st_nx;
    rmode_e            mode_q, mode_nx;
    logic              go_nx;
    op_e               op_nx;
    logic [ADDR_W-1:0] addr_nx;

    always_comb begin
        st_nx   = st_q;
        mode_nx = mode_q;
        go_nx   = 1'b0;
        op_nx   = OP_NONE;
        addr_nx = '0;
        if (wr_fire) begin
            if (st_q == S_PDATA) begin
                st_nx   = S_IDLE;
                go_nx   = 1'b1;
                op_nx   = OP_PROG;
                addr_nx = wr_addr;
            end else if (hit.exit_byte) begin
                st_nx   = S_IDLE;
                mode_nx = RM_ARRAY;
            end else begin
                st_nx = S_IDLE;
                unique case (st_q)
                    S_IDLE: if (hit.key_a) st_nx = S_KEY1;
                    S_KEY1: if (hit.key_b) st_nx = S_KEY2;
                    S_KEY2: begin
                        if (hit.at_a) begin
                            case (wr_data)
                                CMD_PROG:  st_nx   = S_PDATA;
                                CMD_ERASE: st_nx   = S_ERA3;
                                CMD_ID:    mode_nx = RM_ID;
                                CMD_QUERY: mode_nx = RM_QUERY;
                                default:   st_nx   = S_IDLE;
                            endcase
                        end
                    end
                    S_ERA3: if (hit.key_a) st_nx = S_ERA4;
                    S_ERA4: if (hit.key_b) st_nx = S_ERA5;
                    S_ERA5: begin
                        if (wr_data == ERASE_CHIP && hit.at_a) begin
                            go_nx = 1'b1;
                            op_nx = OP_CHIP;
                        end else if (wr_data == ERASE_SECT) begin
                            go_nx   = 1'b1;
                            op_nx   = OP_SECTOR;
                            addr_nx = wr_addr & SECT_MASK;
                        end else if (wr_data == ERASE_BLK) begin
                            go_nx   = 1'b1;
                            op_nx   = OP_BLOCK;
                            addr_nx = wr_addr & BLK_MASK;
                        end
                    end
                    default: st_nx = S_IDLE;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            mode_q <= RM_ARRAY;
        end else begin
            st_q   <= st_nx;
            mode_q <= mode_nx;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            start   <= 1'b0;
            op_code <= OP_NONE;
            op_addr <= '0;
            op_data <= '0;
        end else begin
            start <= go_nx;
            if (go_nx) begin
                op_code <= op_nx;
                op_addr <= addr_nx;
                op_data <= wr_data;
            end
        end
    end

    assign read_mode = mode_q;
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int SECT_BITS = 12,
    parameter int BLK_BITS  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    output logic              start,
    output logic [2:0]        op_code,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic [1:0]        read_mode
);
    match_t hit;
    op_e    op_w;
    rmode_e mode_w;

    nor_cmd_match u_match (
        .addr_lo (wr_addr[CMD_AW-1:0]),
        .data    (wr_data),
        .hit     (hit)
    );

    nor_cmd_fsm #(
        .ADDR_W    (ADDR_W),
        .SECT_BITS (SECT_BITS),
        .BLK_BITS  (BLK_BITS)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .wr_fire   (wr_en && !busy),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .hit       (hit),
        .start     (start),
        .op_code   (op_w),
        .op_addr   (op_addr),
        .op_data   (op_data),
        .read_mode (mode_w)
    );

    assign op_code   = op_w;
    assign read_mode = mode_w;
endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk #(
    parameter int ADDR_W    = 21,
    parameter int SECT_BITS = 12,
    parameter int BLK_BITS  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              busy,
    input logic              start,
    input logic [2:0]        op_code,
    input logic [ADDR_W-1:0] op_addr,
    input logic [1:0]        read_mode
);
    a_r12_start_single: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

    a_r10_busy_no_start: assert property (@(posedge clk) disable iff (rst)
        busy |=> !start);

    a_r10_busy_mode_hold: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(read_mode));

    a_r2_start_needs_write: assert property (@(posedge clk) disable iff (rst)
        start |-> $past(wr_en && !busy));

    a_r4_sector_aligned: assert property (@(posedge clk) disable iff (rst)
        (start && op_code == 3'd2) |-> (op_addr[SECT_BITS-1:0] == '0));

    a_r5_block_aligned: assert property (@(posedge clk) disable iff (rst)
        (start && op_code == 3'd3) |-> (op_addr[BLK_BITS-1:0] == '0));

    a_r12_op_hold: assert property (@(posedge clk) disable iff (rst)
        !start |-> ($stable(op_code) && $stable(op_addr)));

    a_r1_op_valid: assert property (@(posedge clk) disable iff (rst)
        start |-> (op_code >= 3'd1 && op_code <= 3'd4));

    a_r8_quiet_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(read_mode));
endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk #(
    .ADDR_W    (ADDR_W),
    .SECT_BITS (SECT_BITS),
    .BLK_BITS  (BLK_BITS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .busy      (busy),
    .start     (start),
    .op_code   (op_code),
    .op_addr   (op_addr),
    .read_mode (read_mode)
);

// File: tb/nor_cmd_decoder_test.sv
module nor_cmd_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 21;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          busy = 1'b0;
    logic          start;
    logic [2:0]    op_code;
    logic [AW-1:0] op_addr;
    logic [7:0]    op_data;
    logic [1:0]    read_mode;

    int checks = 0;
    int fails  = 0;

    // bench model of the requirements
    int            m_st = 0;   // 0 idle,1 key1,2 key2,3 pdata,4 era3,5 era4,6 era5
    logic [1:0]    m_mode = 0;
    logic          e_start = 0;
    logic [2:0]    e_op = 0;
    logic [AW-1:0] e_addr = 0;
    logic [7:0]    e_data = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_cmd_decoder uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .start(start), .op_code(op_code), .op_addr(op_addr),
        .op_data(op_data), .read_mode(read_mode)
    );

    function automatic logic [AW-1:0] mk(input logic [14:0] lo);
        logic [5:0] hi;
        hi = 6'($urandom);
        return {hi, lo};
    endfunction

    task automatic model_reset();
        m_st = 0; m_mode = 0; e_start = 0; e_op = 0; e_addr = 0; e_data = 0;
    endtask

    task automatic model_step(input logic en, input logic [AW-1:0] a,
                              input logic [7:0] d, input logic b);
        logic [14:0] lo;
        lo = a[14:0];
        e_start = 0;
        if (en && !b) begin
            if (m_st == 3) begin
                e_start = 1; e_op = 1; e_addr = a; e_data = d; m_st = 0;
            end else if (d == 8'hF0) begin
                m_mode = 0; m_st = 0;
            end else begin
                case (m_st)
                    0: m_st = (lo == 15'h5555 && d == 8'hAA) ? 1 : 0;
                    1: m_st = (lo == 15'h2AAA && d == 8'h55) ? 2 : 0;
                    2: begin
                        m_st = 0;
                        if (lo == 15'h5555) begin
                            if (d == 8'hA0) m_st = 3;
                            else if (d == 8'h80) m_st = 4;
                            else if (d == 8'h90) m_mode = 1;
                            else if (d == 8'h98) m_mode = 2;
                        end
                    end
                    4: m_st = (lo == 15'h5555 && d == 8'hAA) ? 5 : 0;
                    5: m_st = (lo == 15'h2AAA && d == 8'h55) ? 6 : 0;
                    6: begin
                        m_st = 0;
                        if (d == 8'h10 && lo == 15'h5555) begin
                            e_start = 1; e_op = 4; e_addr = 0; e_data = d;
                        end else if (d == 8'h30) begin
                            e_start = 1; e_op = 2; e_addr = {a[AW-1:12], 12'h000}; e_data = d;
                        end else if (d == 8'h50) begin
                            e_start = 1; e_op = 3; e_addr = {a[AW-1:16], 16'h0000}; e_data = d;
                        end
                    end
                    default: m_st = 0;
                endcase
            end
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (start !== e_start || op_code !== e_op || op_addr !== e_addr ||
            op_data !== e_data || read_mode !== m_mode) begin
            fails++;
            $display("FAIL %s: start=%0b op=%0d addr=%h data=%h mode=%0d expected start=%0b op=%0d addr=%h data=%h mode=%0d",
                     tag, start, op_code, op_addr, op_data, read_mode,
                     e_start, e_op, e_addr, e_data, m_mode);
        end
    endtask

    // drive at the falling edge, check one time unit after the rising edge
    task automatic step(input logic en, input logic [AW-1:0] a, input logic [7:0] d,
                        input logic b, input string tag);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d; busy = b;
        model_step(en, a, d, b);
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
        step(1'b1, a, d, 1'b0, tag);
    endtask

    task automatic unlock(input string tag);
        wr(mk(15'h5555), 8'hAA, tag);
        wr(mk(15'h2AAA), 8'h55, tag);
    endtask

    task automatic erase_prefix(input string tag);
        unlock(tag);
        wr(mk(15'h5555), 8'h80, tag);
        unlock(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        compare("R1 reset");
        @(negedge clk);
        rst = 1'b0;
        step(1'b0, '0, '0, 1'b0, "R1 idle after reset");

        // R2 program with upper address bits set (R11)
        unlock("R2 R11 key");
        wr(21'h1F5555, 8'hA0, "R2 R11 prog cmd");
        wr(21'h1ABCDE, 8'h3C, "R2 program start");
        step(1'b0, '0, '0, 1'b0, "R12 start single, ops held");
        step(1'b0, '0, '0, 1'b0, "R12 ops held");

        // R13 program data F0
        unlock("R13 key");
        wr(mk(15'h5555), 8'hA0, "R13 cmd");
        wr(21'h00F0F0, 8'hF0, "R13 F0 as data");

        // R3 chip, R4 sector, R5 block
        erase_prefix("R3 prefix");
        wr(mk(15'h5555), 8'h10, "R3 chip erase");
        erase_prefix("R4 prefix");
        wr(21'h12345, 8'h30, "R4 sector erase");
        erase_prefix("R5 prefix");
        wr(21'h1ABCDE, 8'h50, "R5 block erase");
        step(1'b0, '0, '0, 1'b0, "R12 after block");

        // R6, R7
        unlock("R6 key");
        wr(mk(15'h5555), 8'h90, "R6 id entry");
        unlock("R6 key2");
        wr(mk(15'h5555), 8'h98, "R6 query entry from id");
        unlock("R7 key");
        wr(mk(15'h5555), 8'hF0, "R7 three-write exit");

        // R8 single exit mid-sequence
        unlock("R8 key");
        wr(mk(15'h5555), 8'h90, "R8 id entry");
        unlock("R8 partial");
        wr(21'h000777, 8'hF0, "R8 single exit");
        wr(mk(15'h5555), 8'hA0, "R8 no longer unlocked");
        wr(mk(15'h1234), 8'h11, "R8 no start");

        // R9 mismatch in id mode
        unlock("R9 key");
        wr(mk(15'h5555), 8'h90, "R9 id entry");
        wr(mk(15'h5555), 8'hAA, "R9 key a");
        wr(mk(15'h2AAA), 8'h56, "R9 wrong byte");
        wr(mk(15'h2AAA), 8'h55, "R9 stale key b");
        wr(mk(15'h5555), 8'hA0, "R9 stale cmd");
        wr(mk(15'h0042), 8'h99, "R9 no start");
        erase_prefix("R9 erase prefix");
        wr(mk(15'h5554), 8'h10, "R9 chip at wrong address");

        // R10 busy writes ignored
        unlock("R10 key");
        step(1'b1, mk(15'h0000), 8'hF0, 1'b1, "R10 busy exit ignored");
        step(1'b1, mk(15'h5555), 8'hAA, 1'b1, "R10 busy key ignored");
        wr(mk(15'h5555), 8'hA0, "R10 sequence kept");
        step(1'b1, 21'h000100, 8'h77, 1'b1, "R10 busy data ignored");
        wr(21'h000200, 8'h66, "R10 program after busy");
        unlock("R7 exit key");
        wr(mk(15'h5555), 8'hF0, "R7 exit");

        // constrained random command streams
        for (int it = 0; it < 400; it++) begin
            logic [AW-1:0] sa [6];
            logic [7:0]    sd [6];
            int n, k, bad;
            k = int'($urandom % 9);
            sa[0] = mk(15'h5555); sd[0] = 8'hAA;
            sa[1] = mk(15'h2AAA); sd[1] = 8'h55;
            sa[2] = mk(15'h5555);
            sa[3] = mk(15'h5555); sd[3] = 8'hAA;
            sa[4] = mk(15'h2AAA); sd[4] = 8'h55;
            sa[5] = mk(15'h5555); sd[5] = 8'h10;
            n = 3;
            case (k)
                0: begin sd[2] = 8'hA0; n = 4; sa[3] = 21'($urandom); sd[3] = 8'($urandom); end
                1: begin sd[2] = 8'h80; n = 6; end
                2: begin sd[2] = 8'h80; n = 6; sa[5] = 21'($urandom); sd[5] = 8'h30; end
                3: begin sd[2] = 8'h80; n = 6; sa[5] = 21'($urandom); sd[5] = 8'h50; end
                4: sd[2] = 8'h90;
                5: sd[2] = 8'h98;
                6: sd[2] = 8'hF0;
                7: begin n = 1; sa[0] = 21'($urandom); sd[0] = 8'hF0; end
                default: begin n = 1; sa[0] = 21'($urandom); sd[0] = 8'($urandom); end
            endcase
            bad = ($urandom % 6 == 0) ? int'($urandom % n) : -1;
            for (int i = 0; i < n; i++) begin
                logic [7:0] d;
                logic b;
                d = (i == bad) ? (sd[i] ^ 8'(1 + $urandom % 255)) : sd[i];
                b = ($urandom % 12 == 0);
                step(1'b1, sa[i], d, b, "R9 R10 R11 random stream");
                if ($urandom % 5 == 0) step(1'b0, 21'($urandom), 8'($urandom), 1'($urandom), "R12 random gap");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule